// File: doc/BRIEF.md
# Six-Control-Bit Arithmetic-Logic Unit

This block is the combinational arithmetic-logic stage of a small accumulator-style processor. It takes two 16-bit operands and a 6-bit control word. Each operand can be cleared to zero, bitwise complemented, or both. The conditioned operands are then either added in two's complement or combined with bitwise AND. The result can optionally be complemented at the end. Because every operation is built from these six independent conditioning bits, no opcode table is needed. Constants, negation, increment, decrement, subtraction in either order and bitwise OR all come from suitable bit patterns.

The result drives two status flags, a zero flag and a negative flag, which later jump logic in the processor consumes. The control word is laid out so that it can be wired straight from an instruction's compute field. There is no state inside the block, so every output follows its inputs within the same cycle.

Top module: `alu6_top`

## Requirements
- R1: Control bit 5 (`clr_x`), when 1, replaces the x operand with zero before any other conditioning.
- R2: Control bit 4 (`inv_x`), when 1, complements the x operand bitwise after the `clr_x` step. With both bits set, the x operand becomes 0xFFFF.
- R3: Control bits 3 (`clr_y`) and 2 (`inv_y`) condition the y operand in the same way, and in the same order, as R1 and R2 condition x.
- R4: Control bit 1 (`sel_add`) = 1 makes the core result the sum of the conditioned operands modulo 2^16. No carry or overflow is reported, so 0xFFFF + 0x0001 gives 0x0000.
- R5: Control bit 1 (`sel_add`) = 0 makes the core result the bitwise AND of the conditioned operands.
- R6: Control bit 0 (`inv_out`), when 1, complements the core result bitwise to give `result`.
- R7: `zero_flag` is 1 exactly when `result` equals 0x0000.
- R8: `neg_flag` is 1 exactly when bit 15 of the final `result` is 1, that is, when the result is negative in two's complement.
- R9: The 18 standard control codes produce the intended functions on arbitrary operands. With bits 5..0 shown as hex, they are:
  - constants: 0x2A gives 0, 0x3F gives 1, 0x3A gives -1
  - pass and complement: 0x0C gives x, 0x30 gives y, 0x0D gives ~x, 0x31 gives ~y
  - negation: 0x0F gives -x, 0x33 gives -y
  - increment and decrement: 0x1F gives x+1, 0x37 gives y+1, 0x0E gives x-1, 0x32 gives y-1
  - two-operand: 0x02 gives x+y, 0x13 gives x-y, 0x07 gives y-x, 0x00 gives x&y, 0x15 gives x|y
- R10: All outputs are a combinational function of the present inputs, with no internal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| ctl | input | 6 | Control word: bits 5..0 are clr_x, inv_x, clr_y, inv_y, sel_add, inv_out |
| result | output | 16 | Final result |
| zero_flag | output | 1 | High when result is zero |
| neg_flag | output | 1 | High when result bit 15 is set |

## Verification
Every result and flag is due in the same cycle that its operands and control word are applied, because the block holds no registers. The bench changes the inputs shortly after a clock edge and reads the outputs a short delay later, still well before the next edge. Each sample therefore reflects only the stimulus just applied. The bench also never waits a cycle and so cannot hide a latch or a stray register. The expected values come from a bench-side model of the 18 named functions and from hand-worked corner operands.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

    localparam int CTL_W = 6;

    // Bit order is fixed by the instruction compute field: bit 5 first.
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic sel_add;
        logic inv_out;
    } alu6_ctl_t;

    typedef struct packed {
        logic clr;
        logic inv;
    } opnd_mode_t;

    function automatic opnd_mode_t mode_of_x(alu6_ctl_t c);
        opnd_mode_t m;
        m.clr = c.clr_x;
        m.inv = c.inv_x;
        return m;
    endfunction

    function automatic opnd_mode_t mode_of_y(alu6_ctl_t c);
        opnd_mode_t m;
        m.clr = c.clr_y;
        m.inv = c.inv_y;
        return m;
    endfunction

endpackage

// File: rtl/alu6_operand.sv
module alu6_operand
    import alu6_pkg::*;
#(
    parameter int W = 16
) (
    input  opnd_mode_t     mode,
    input  logic [W-1:0]   raw,
    output logic [W-1:0]   cond
);
    logic [W-1:0] cleared;

    // Clearing happens first, complementing second.
    always_comb begin
        cleared = mode.clr ? '0 : raw;
        cond    = mode.inv ? ~cleared : cleared;
    end
endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] y
);
    logic [W-1:0] sum_v;
    logic [W-1:0] and_v;
    logic [W-1:0] pick;

    always_comb begin
        sum_v = a + b;
        and_v = a & b;
        pick  = sel_add ? sum_v : and_v;
        y     = inv_out ? ~pick : pick;
    end
endmodule

// File: rtl/alu6_flags.sv
module alu6_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    always_comb begin
        is_zero = ~|res;
        is_neg  = res[W-1];
    end
endmodule

// File: rtl/alu6_top.sv
module alu6_top
    import alu6_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]       x_in,
    input  logic [W-1:0]       y_in,
    input  logic [CTL_W-1:0]   ctl,
    output logic [W-1:0]       result,
    output logic               zero_flag,
    output logic               neg_flag
);
    localparam int N_OPND = 2;

    alu6_ctl_t    ctl_s;
    opnd_mode_t   mode   [N_OPND];
    logic [W-1:0] raw_op [N_OPND];
    logic [W-1:0] cond_op[N_OPND];

    always_comb begin
        ctl_s     = alu6_ctl_t'(ctl);
        mode[0]   = mode_of_x(ctl_s);
        mode[1]   = mode_of_y(ctl_s);
        raw_op[0] = x_in;
        raw_op[1] = y_in;
    end

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        alu6_operand #(.W(W)) u_opnd (
            .mode (mode[i]),
            .raw  (raw_op[i]),
            .cond (cond_op[i])
        );
    end

    alu6_core #(.W(W)) u_core (
        .a       (cond_op[0]),
        .b       (cond_op[1]),
        .sel_add (ctl_s.sel_add),
        .inv_out (ctl_s.inv_out),
        .y       (result)
    );

    alu6_flags #(.W(W)) u_flags (
        .res     (result),
        .is_zero (zero_flag),
        .is_neg  (neg_flag)
    );
endmodule

// File: rtl/alu6_chk.sv
module alu6_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] x_in,
    input logic [W-1:0] y_in,
    input logic [5:0]   ctl,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         neg_flag
);
    always_comb begin
        a_r7_zero_flag: assert (zero_flag == (result == '0));
        a_r8_neg_flag:  assert (neg_flag == result[W-1]);
        if (ctl == 6'b000000)
            a_r5_and: assert (result == (x_in & y_in));
        if (ctl == 6'b000010)
            a_r4_add: assert (result == W'(x_in + y_in));
        if (ctl == 6'b101010)
            a_r1_clear_x: assert (result == '0);
        if (ctl == 6'b111111)
            a_r2_const_one: assert (result == W'(1));
        if (ctl == 6'b000001)
            a_r6_inv_out: assert (result == ~(x_in & y_in));
    end
endmodule

bind alu6_top alu6_chk #(.W(W)) u_chk (
    .x_in      (x_in),
    .y_in      (y_in),
    .ctl       (ctl),
    .result    (result),
    .zero_flag (zero_flag),
    .neg_flag  (neg_flag)
);

// File: tb/alu6_top_tb.sv
`timescale 1ns/1ps
module alu6_top_tb;
    logic        clk = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [5:0]  ctl  = '0;
    logic [15:0] result;
    logic        zero_flag;
    logic        neg_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu6_top u_dut (
        .x_in      (x_in),
        .y_in      (y_in),
        .ctl       (ctl),
        .result    (result),
        .zero_flag (zero_flag),
        .neg_flag  (neg_flag)
    );

    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [5:0] c);
        @(posedge clk);
        #0.5;
        x_in = x; y_in = y; ctl = c;
        #1.5;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s ctl=%b x=%h y=%h got=%h exp=%h", req, ctl, x_in, y_in, got, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
        case (c)
            6'h2A: return 16'h0000;
            6'h3F: return 16'h0001;
            6'h3A: return 16'hFFFF;
            6'h0C: return x;
            6'h30: return y;
            6'h0D: return ~x;
            6'h31: return ~y;
            6'h0F: return 16'(-x);
            6'h33: return 16'(-y);
            6'h1F: return 16'(x + 16'd1);
            6'h37: return 16'(y + 16'd1);
            6'h0E: return 16'(x - 16'd1);
            6'h32: return 16'(y - 16'd1);
            6'h02: return 16'(x + y);
            6'h13: return 16'(x - y);
            6'h07: return 16'(y - x);
            6'h00: return x & y;
            default: return x | y;
        endcase
    endfunction

    // R7, R8: flags checked against the expected result
    task automatic chk_flags(input string req, input logic [15:0] exp);
        chk({req, " R7 zero"}, {15'd0, zero_flag}, {15'd0, exp == 16'h0000});
        chk({req, " R8 neg"},  {15'd0, neg_flag},  {15'd0, exp[15]});
    endtask

    task automatic test_standard_codes();
        logic [5:0] codes [18] = '{6'h2A, 6'h3F, 6'h3A, 6'h0C, 6'h30, 6'h0D, 6'h31, 6'h0F,
                                   6'h33, 6'h1F, 6'h37, 6'h0E, 6'h32, 6'h02, 6'h13, 6'h07,
                                   6'h00, 6'h15};
        for (int i = 0; i < 18; i++) begin
            for (int k = 0; k < 24; k++) begin
                logic [15:0] x, y, e;
                x = 16'($urandom);
                y = 16'($urandom);
                if (k == 0) begin x = 16'h0000; y = 16'h0000; end
                if (k == 1) begin x = 16'h8000; y = 16'h7FFF; end
                if (k == 2) begin x = 16'hFFFF; y = 16'h0001; end
                apply(x, y, codes[i]);
                e = model(codes[i], x, y);
                chk("R9 standard code", result, e);
                chk_flags("R9", e);
            end
        end
    endtask

    task automatic test_clear_then_invert();
        // R1/R2: clr_x+inv_x with AND passes y (x became 0xFFFF)
        apply(16'h1234, 16'hA5C3, 6'b110000);
        chk("R2 order x", result, 16'hA5C3);
        // R3: clr_y+inv_y with AND passes x
        apply(16'h5A0F, 16'h9999, 6'b001100);
        chk("R3 order y", result, 16'h5A0F);
        // R1: clr_x alone with add gives y
        apply(16'hBEEF, 16'h0102, 6'b100010);
        chk("R1 clear x", result, 16'h0102);
        // R3: clr_y alone with add gives x
        apply(16'hBEEF, 16'h0102, 6'b001010);
        chk("R3 clear y", result, 16'hBEEF);
        // R2: inv_x alone with AND
        apply(16'h00FF, 16'h0F0F, 6'b010000);
        chk("R2 invert x", result, 16'h0F00);
    endtask

    task automatic test_wrap_and_flags();
        apply(16'hFFFF, 16'h0001, 6'b000010);
        chk("R4 wrap", result, 16'h0000);
        chk_flags("R4 wrap", 16'h0000);
        apply(16'h7FFF, 16'h0001, 6'b000010);
        chk("R4 signed overflow", result, 16'h8000);
        chk_flags("R4 overflow", 16'h8000);
        apply(16'hF0F0, 16'h3C3C, 6'b000000);
        chk("R5 and", result, 16'h3030);
        apply(16'hF0F0, 16'h3C3C, 6'b000001);
        chk("R6 inv out", result, 16'hCFCF);
        chk_flags("R6", 16'hCFCF);
    endtask

    task automatic test_no_state();
        // R10: same inputs give same output irrespective of history
        apply(16'h1111, 16'h2222, 6'b000010);
        apply(16'hAAAA, 16'h5555, 6'b000010);
        chk("R10 comb a", result, 16'hFFFF);
        apply(16'h1111, 16'h2222, 6'b000010);
        chk("R10 comb b", result, 16'h3333);
    endtask

    initial begin
        #2;
        chk("R10 initial x&y", result, 16'h0000);
        chk("R7 initial zero", {15'd0, zero_flag}, 16'h0001);
        test_clear_then_invert();
        test_wrap_and_flags();
        test_no_state();
        test_standard_codes();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule